// File: doc/BRIEF.md
# Ten-State Scrambled-Order Counter

This block is a synchronous 4-bit counter that walks a fixed loop of ten codes. It does not count in binary or BCD order. Each rising clock edge with the count enable high moves it one step along the loop: 0, 7, 6, 13, 12, 5, 4, 3, 2, 1, and then back to 0. Apart from the jump through 13 and 12, the counter runs downward from 7 to 0.

The four state bits appear on separate pins `q1`..`q4`. A 4-bit numeric view appears on `value`, in which `q1` is the least significant bit. The six codes outside the loop are 8, 9, 10, 11, 14 and 15. From any of them the counter returns to 0 on the next enabled edge. The reset value is set by the parameter `INIT`, which defaults to 0. Because the block has no load mode, this parameter is the only way a design can start the counter on an unused code.

Top module: `scramble_count10`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads `INIT` (default 0) into the state, and it does so whatever the value of `en`.
- R2: When `rst` is low and `en` is low at an edge, the state does not change.
- R3: With `en` high, a legal state moves to its successor in the loop 0→7→6→13→12→5→4→3→2→1→0.
- R4: With `en` high, the unused codes 8, 9, 10, 11, 14 and 15 go to 0 on the next edge.
- R5: `value` equals 8·`q4` + 4·`q3` + 2·`q2` + `q1`, so that `q1` is bit 0 and `q4` is bit 3.
- R6: Once the state is legal, it stays legal under any sequence of enabled steps, and it returns to the same code after ten steps.
- R7: An unused code holds while `en` is low, and recovery waits for the first enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; loads INIT |
| en | input | 1 | Count enable |
| q1 | output | 1 | State bit, weight 1 |
| q2 | output | 1 | State bit, weight 2 |
| q3 | output | 1 | State bit, weight 4 |
| q4 | output | 1 | State bit, weight 8 |
| value | output | 4 | Numeric view of the state {q4,q3,q2,q1} |

## Verification
The bench builds one instance with the default `INIT` of 0, which drives the loop through two full turns, the enable gaps and a reset asserted during counting. The bench also builds six more instances, one with `INIT` set to each unused code (8, 9, 10, 11, 14, 15). Those instances make the recovery path reachable without a load port. Through them the bench checks that an unused code holds while enable is low, and that it falls to 0 on the first enabled edge.

// File: rtl/scramble_count10.sv
module scramble_count10 #(
  parameter logic [3:0] INIT = 4'd0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic       q1,
  output logic       q2,
  output logic       q3,
  output logic       q4,
  output logic [3:0] value
);

  logic [3:0] st;
  logic [3:0] nxt;

  always_comb begin
    case (st)
      4'd0:    nxt = 4'd7;
      4'd7:    nxt = 4'd6;
      4'd6:    nxt = 4'd13;
      4'd13:   nxt = 4'd12;
      4'd12:   nxt = 4'd5;
      4'd5:    nxt = 4'd4;
      4'd4:    nxt = 4'd3;
      4'd3:    nxt = 4'd2;
      4'd2:    nxt = 4'd1;
      4'd1:    nxt = 4'd0;
      default: nxt = 4'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     st <= INIT;
    else if (en) st <= nxt;
  end

  assign q1    = st[0];
  assign q2    = st[1];
  assign q3    = st[2];
  assign q4    = st[3];
  assign value = {q4, q3, q2, q1};

endmodule

// File: rtl/scramble_count10_chk.sv
module scramble_count10_chk #(
  parameter logic [3:0] INIT = 4'd0
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [3:0] value
);

  logic primed = 1'b0;
  always_ff @(posedge clk) if (rst) primed <= 1'b1;

  function automatic logic unused_code(input logic [3:0] v);
    return (v == 4'd8) || (v == 4'd9) || (v == 4'd10) ||
           (v == 4'd11) || (v == 4'd14) || (v == 4'd15);
  endfunction

  a_r1_reset_load: assert property (@(posedge clk) rst |=> value == INIT);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    primed && !en |=> $stable(value));

  a_r3_zero_to_seven: assert property (@(posedge clk) disable iff (rst)
    primed && en && value == 4'd0 |=> value == 4'd7);

  a_r3_six_to_thirteen: assert property (@(posedge clk) disable iff (rst)
    primed && en && value == 4'd6 |=> value == 4'd13);

  a_r3_twelve_to_five: assert property (@(posedge clk) disable iff (rst)
    primed && en && value == 4'd12 |=> value == 4'd5);

  a_r3_one_to_zero: assert property (@(posedge clk) disable iff (rst)
    primed && en && value == 4'd1 |=> value == 4'd0);

  a_r4_unused_recover: assert property (@(posedge clk) disable iff (rst)
    primed && en && unused_code(value) |=> value == 4'd0);

  a_r6_stays_legal: assert property (@(posedge clk) disable iff (rst)
    primed && en |=> !unused_code(value));

endmodule

bind scramble_count10 scramble_count10_chk #(.INIT(INIT)) u_chk (
  .clk(clk), .rst(rst), .en(en), .value(value)
);

// File: tb/scramble_count10_test.sv
module scramble_count10_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  always #2.5 clk = ~clk;

  localparam int NR = 7;
  localparam logic [3:0] INITS [NR] = '{4'd0, 4'd8, 4'd9, 4'd10, 4'd11, 4'd14, 4'd15};

  logic       q1 [NR];
  logic       q2 [NR];
  logic       q3 [NR];
  logic       q4 [NR];
  logic [3:0] val[NR];

  for (genvar g = 0; g < NR; g++) begin : g_dut
    if (g == 0) begin : g_main
      scramble_count10 uut (
        .clk(clk), .rst(rst), .en(en),
        .q1(q1[g]), .q2(q2[g]), .q3(q3[g]), .q4(q4[g]), .value(val[g])
      );
    end else begin : g_rec
      scramble_count10 #(.INIT(INITS[g])) uut (
        .clk(clk), .rst(rst), .en(en),
        .q1(q1[g]), .q2(q2[g]), .q3(q3[g]), .q4(q4[g]), .value(val[g])
      );
    end
  end

  int loop_order[$] = '{0, 7, 6, 13, 12, 5, 4, 3, 2, 1};
  int model[NR];
  string tag[NR];
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) begin
    for (int i = 0; i < NR; i++) begin
      int idx[$];
      if (rst) begin
        model[i] <= int'(INITS[i]);
        tag[i] <= "R1";
      end else if (!en) begin
        tag[i] <= (model[i] inside {8, 9, 10, 11, 14, 15}) ? "R7" : "R2";
      end else begin
        idx = loop_order.find_first_index(x) with (x == model[i]);
        if (idx.size() == 0) begin
          model[i] <= 0;
          tag[i] <= "R4";
        end else begin
          model[i] <= loop_order[(idx[0] + 1) % 10];
          tag[i] <= "R3";
        end
      end
    end
    live <= 1'b1;
  end

  always @(negedge clk) begin
    if (live && !done) begin
      for (int i = 0; i < NR; i++) begin
        checks++;
        if (int'(val[i]) != model[i]) begin
          fails++;
          $display("FAIL %s inst%0d value=%0d expected=%0d", tag[i], i, val[i], model[i]);
        end
        checks++;
        if (int'(val[i]) != 8*q4[i] + 4*q3[i] + 2*q2[i] + q1[i]) begin
          fails++;
          $display("FAIL R5 inst%0d value=%0d expected=%0d", i, val[i],
                   8*q4[i] + 4*q3[i] + 2*q2[i] + q1[i]);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic step(input bit r, input bit e, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      rst = r;
      en  = e;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog cycles=%0d expected=<5000", cycles);
      finish_run();
    end
  end

  initial begin
    step(1, 0, 2);   // R1: reset state, with en low
    step(1, 1, 1);   // R1: reset wins over en
    step(0, 0, 3);   // R2 and R7: hold, unused codes wait
    step(0, 1, 20);  // R3, R4, R6: two full turns, recovery
    step(0, 0, 2);   // R2
    step(0, 1, 3);
    step(0, 0, 1);
    step(0, 1, 4);
    step(1, 1, 1);   // R1: reset during counting
    step(0, 1, 1);   // R4: recovery from unused codes again
    step(0, 1, 12);  // R6: loop repeats
    step(0, 0, 2);
    finish_run();
  end

endmodule